// File: doc/BRIEF.md
# Power-Down Wake-Up Settle Controller

This block decides when a sleeping core may run again. A power-down request stops the oscillator and gates the core clock. It also takes a snapshot of the interrupt enables and the settle-time code in force at that moment. While asleep, the block watches ten external interrupt lines. A line wakes the device only if both the global enable and that line's own enable were set when power-down began. The line must also stay active for longer than a minimum hold time.

A qualified wake turns the oscillator back on at once and pulses a wake event. The core clock stays gated while a counter runs through the chosen number of oscillator periods. The clock is then released. The settle length is the base count of 192 periods doubled once per step of a 3-bit code. A select register holds the code and comes out of reset at the mid-range value. The `clk` input is the always-running reference, and each of its cycles counts as one oscillator period.

Top module: `pd_wake_ctrl`

## Requirements
- R1: After reset, `osc_en` and `core_clk_en` are 1, `wake_evt` is 0 and the stored select code is 3.
- R2: When `pd_req` is sampled high while running, `osc_en` and `core_clk_en` are both 0 from the next cycle on.
- R3: An armed line sampled high on 25 consecutive clock edges while powered down (more than 24) causes a wake. After the 25th edge, `wake_evt` and `osc_en` are 1 and `core_clk_en` is still 0.
- R4: A line held high for 24 edges or fewer, then dropped, causes no wake: `osc_en` stays 0.
- R5: If `glob_en` was 0 when power-down was entered, no line activity causes a wake.
- R6: A line whose `line_en` bit was 0 when power-down was entered is ignored, even if its enable is set later during power-down.
- R7: The settle length is D = 192 × 2^code, with codes 0..7 giving 192..24576. `core_clk_en` is 0 through the cycle D−1 edges after the wake edge and becomes 1 exactly D edges after it.
- R8: With no write since reset, a wake uses code 3, which gives 1536 periods.
- R9: The code is sampled on power-down entry. A write through `sel_wr`/`sel_in` during power-down or settling has no effect on the wake in progress, and it applies to the next power-down.
- R10: `pd_req` is ignored while settling: `osc_en` stays 1 and the clock is still released at D.
- R11: `wake_evt` is high for exactly one cycle per wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock, one oscillator period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | Request to enter power-down |
| irq_in | input | 10 | External interrupt lines, active high |
| glob_en | input | 1 | Global interrupt enable |
| line_en | input | 10 | Per-line interrupt enables |
| sel_wr | input | 1 | Write strobe for the settle-code register |
| sel_in | input | 3 | New settle code |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Internal core clock enable |
| wake_evt | output | 1 | One-cycle pulse when a wake is accepted |

## Verification
The bench uses the default parameters: ten lines, a 3-bit code, a base of 192 periods and a 24-period hold minimum. With these values the longest settle of 24576 periods and the exact hold boundary of 24 versus 25 edges can both be reached within the cycle budget. Directed cases cover the reset default code and the smallest and largest codes. They also cover an enable or code change made after entry. Random cases draw codes 0..4 and random lines.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic [1:0] {
    PDW_RUN    = 2'd0,
    PDW_DOWN   = 2'd1,
    PDW_SETTLE = 2'd2
  } pdw_state_e;
endpackage

// File: rtl/pdw_line_filter.sv
module pdw_line_filter #(
  parameter int unsigned HOLD_MIN = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic watch,
  input  logic level,
  output logic hit
);
  localparam int unsigned HCW = $clog2(HOLD_MIN + 1);
  localparam logic [HCW-1:0] HOLD_V = HCW'(HOLD_MIN);

  logic [HCW-1:0] cnt_q;

  // Counts consecutive sampled-high edges; clears on any gap.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!(watch && level)) begin
      cnt_q <= '0;
    end else if (cnt_q != HOLD_V) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit = watch && level && (cnt_q == HOLD_V);

  a_r4_cnt_sat: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= HOLD_V) else $error("R4 hold counter overran");

  a_r4_hit_needs_hold: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(watch && level)) else $error("R4 hit without held level");
endmodule

// File: rtl/pdw_settle_timer.sv
module pdw_settle_timer #(
  parameter int unsigned SEL_W        = 3,
  parameter int unsigned BASE_PERIODS = 192
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int unsigned MAX_LIM = BASE_PERIODS << ((1 << SEL_W) - 1);
  localparam int unsigned CNT_W   = $clog2(MAX_LIM);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [CNT_W:0]   lim;

  assign lim  = (CNT_W + 1)'(BASE_PERIODS) << sel;
  assign done = run_q && ({1'b0, cnt_q} == (lim - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (done) run_q <= 1'b0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r7_cnt_range: assert property (@(posedge clk) disable iff (rst)
    run_q |-> ({1'b0, cnt_q} < lim)) else $error("R7 settle count beyond limit");

  a_r7_start_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !run_q) else $error("R7 restart while counting");
endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl #(
  parameter int unsigned NUM_LINES    = 10,
  parameter int unsigned SEL_W        = 3,
  parameter int unsigned BASE_PERIODS = 192,
  parameter int unsigned HOLD_MIN     = 24,
  parameter int unsigned SEL_RST      = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pd_req,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 glob_en,
  input  logic [NUM_LINES-1:0] line_en,
  input  logic                 sel_wr,
  input  logic [SEL_W-1:0]     sel_in,
  output logic                 osc_en,
  output logic                 core_clk_en,
  output logic                 wake_evt
);
  import pdw_pkg::*;

  localparam logic [SEL_W-1:0] SEL_DEF = SEL_W'(SEL_RST);

  pdw_state_e           state_q;
  logic [NUM_LINES-1:0] armed_q;
  logic [SEL_W-1:0]     sel_reg_q;
  logic [SEL_W-1:0]     sel_act_q;
  logic [NUM_LINES-1:0] hit;
  logic                 asleep;
  logic                 wake_go;
  logic                 settle_done;

  assign asleep  = (state_q == PDW_DOWN);
  assign wake_go = asleep && (|hit);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    pdw_line_filter #(.HOLD_MIN(HOLD_MIN)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .watch (asleep && armed_q[i]),
      .level (irq_in[i]),
      .hit   (hit[i])
    );
  end

  pdw_settle_timer #(.SEL_W(SEL_W), .BASE_PERIODS(BASE_PERIODS)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (wake_go),
    .sel   (sel_act_q),
    .done  (settle_done)
  );

  always_ff @(posedge clk) begin
    if (rst)         sel_reg_q <= SEL_DEF;
    else if (sel_wr) sel_reg_q <= sel_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PDW_RUN;
      osc_en      <= 1'b1;
      core_clk_en <= 1'b1;
      wake_evt    <= 1'b0;
      armed_q     <= '0;
      sel_act_q   <= SEL_DEF;
    end else begin
      wake_evt <= 1'b0;
      unique case (state_q)
        PDW_RUN: begin
          if (pd_req) begin
            state_q     <= PDW_DOWN;
            osc_en      <= 1'b0;
            core_clk_en <= 1'b0;
            armed_q     <= glob_en ? line_en : '0;
            sel_act_q   <= sel_reg_q;
          end
        end
        PDW_DOWN: begin
          if (wake_go) begin
            state_q  <= PDW_SETTLE;
            osc_en   <= 1'b1;
            wake_evt <= 1'b1;
            armed_q  <= '0;
          end
        end
        PDW_SETTLE: begin
          if (settle_done) begin
            state_q     <= PDW_RUN;
            core_clk_en <= 1'b1;
          end
        end
        default: state_q <= PDW_RUN;
      endcase
    end
  end

  a_r11_evt_single: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> !wake_evt) else $error("R11 wake event longer than one cycle");

  a_r2_clk_needs_osc: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> osc_en) else $error("R2 core clock without oscillator");

  a_r3_evt_gated: assert property (@(posedge clk) disable iff (rst)
    wake_evt |-> (osc_en && !core_clk_en)) else $error("R3 wake event with wrong enables");

  a_r5_wake_armed: assert property (@(posedge clk) disable iff (rst)
    wake_go |-> (|armed_q)) else $error("R5 wake with nothing armed");

  a_r10_settle_osc: assert property (@(posedge clk) disable iff (rst)
    (state_q == PDW_SETTLE) |-> osc_en) else $error("R10 oscillator dropped while settling");
endmodule

// File: tb/test_pd_wake_ctrl.sv
module test_pd_wake_ctrl;
  localparam int NL   = 10;
  localparam int HOLD = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pd_req = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic          glob_en = 1'b0;
  logic [NL-1:0] line_en = '0;
  logic          sel_wr = 1'b0;
  logic [2:0]    sel_in = '0;
  logic          osc_en, core_clk_en, wake_evt;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  pd_wake_ctrl i_pd_wake_ctrl (
    .clk(clk), .rst(rst), .pd_req(pd_req), .irq_in(irq_in),
    .glob_en(glob_en), .line_en(line_en), .sel_wr(sel_wr), .sel_in(sel_in),
    .osc_en(osc_en), .core_clk_en(core_clk_en), .wake_evt(wake_evt)
  );

  function automatic int exp_delay(input int code);
    return 192 << code;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_sel(input int code);
    sel_wr = 1'b1; sel_in = 3'(code);
    step();
    sel_wr = 1'b0;
  endtask

  task automatic enter_pd(input logic g, input logic [NL-1:0] en);
    glob_en = g; line_en = en; pd_req = 1'b1;
    step();
    pd_req = 1'b0;
    check("R2 osc_en after entry", int'(osc_en), 0);
    check("R2 core_clk_en after entry", int'(core_clk_en), 0);
  endtask

  // Raises one line, expects the wake after HOLD+1 edges and the clock after D more.
  task automatic run_wake(input int line, input int code, input bit poke_pd);
    int d;
    d = exp_delay(code);
    irq_in[line] = 1'b1;
    for (int k = 1; k <= HOLD + 1; k++) begin
      step();
      if (k == HOLD) check("R3 no wake at 24 edges", int'(wake_evt), 0);
    end
    check("R3 wake_evt after 25 edges", int'(wake_evt), 1);
    check("R3 osc_en on wake", int'(osc_en), 1);
    check("R3 core_clk_en gated on wake", int'(core_clk_en), 0);
    irq_in[line] = 1'b0;
    for (int k = 1; k <= d; k++) begin
      if (poke_pd && k == 2) pd_req = 1'b1;
      if (poke_pd && k == 3) pd_req = 1'b0;
      if (k == 1) write_sel(7 - code);
      else step();
      if (k == 1) check("R11 wake_evt single cycle", int'(wake_evt), 0);
      if (poke_pd && k == 4) check("R10 osc_en held while settling", int'(osc_en), 1);
      if (k == d - 1) check("R7 clock gated at D-1", int'(core_clk_en), 0);
    end
    check("R7 clock released at D", int'(core_clk_en), 1);
    check("R7 osc_en at D", int'(osc_en), 1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd11));
    step(); step();
    rst = 1'b0;
    check("R1 osc_en reset", int'(osc_en), 1);
    check("R1 core_clk_en reset", int'(core_clk_en), 1);
    check("R1 wake_evt reset", int'(wake_evt), 0);

    // R4 then R8: short pulse ignored, then default code 3 (1536)
    enter_pd(1'b1, '1);
    irq_in[2] = 1'b1;
    for (int k = 0; k < HOLD; k++) step();
    irq_in[2] = 1'b0;
    for (int k = 0; k < 30; k++) step();
    check("R4 short pulse keeps osc off", int'(osc_en), 0);
    write_sel(3);
    do_reset();
    enter_pd(1'b1, '1);
    run_wake(2, 3, 1'b0);  // R8 default after reset
    write_sel(3);

    // R5: global enable clear at entry
    enter_pd(1'b0, '1);
    irq_in = '1;
    for (int k = 0; k < 40; k++) step();
    check("R5 no wake without global enable", int'(osc_en), 0);
    check("R5 no wake event", int'(wake_evt), 0);
    irq_in = '0;
    do_reset();
    check("R1 osc_en after second reset", int'(osc_en), 1);

    // R6: line not enabled at entry, enabled later
    enter_pd(1'b1, NL'(1));
    line_en = '1;
    irq_in[5] = 1'b1;
    for (int k = 0; k < 40; k++) step();
    check("R6 unarmed line ignored", int'(osc_en), 0);
    irq_in[5] = 1'b0;
    step();
    run_wake(0, 3, 1'b0);

    // R9 and R10: code 0 captured, write 7 during settle applies next time
    write_sel(0);
    enter_pd(1'b1, '1);
    write_sel(5);
    run_wake(4, 0, 1'b1);   // writes 7 during settle
    enter_pd(1'b1, '1);
    run_wake(9, 7, 1'b0);   // R9 new code applies: 24576

    // random cases
    for (int it = 0; it < 6; it++) begin
      int code, line;
      logic [NL-1:0] en;
      code = int'($urandom % 5);
      line = int'($urandom % NL);
      en = NL'($urandom) | (NL'(1) << line);
      write_sel(code);
      enter_pd(1'b1, en);
      run_wake(line, code, 1'b0);
      write_sel(code);
    end
    finish_up();
  end
endmodule